// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the raster timing for a flat panel: horizontal sync, vertical sync, a data-enable window, a pixel clock (as a level and as a one-cycle enable pulse), an AC-bias output, the active pixel coordinates and a pixel-request strobe. It handles no pixel data. A pixel fetch unit uses the coordinates and strobes to supply data in step with the scan.

Timing comes from three packed 32-bit configuration words: horizontal geometry, vertical geometry, and a third word holding the pixel clock divider, the AC-bias line count and six output polarity bits. A panel-type input selects thin-film (TFT) or passive operation. All configuration is captured into shadow registers at the start of each frame, so software may rewrite it at any time without tearing the current frame.

Scanning starts when the enable input is sampled high while idle. When enable is low at the last pixel period of a frame, the block stops at that frame boundary and raises a one-cycle done pulse. It never truncates a frame.

Top module: `lcd_timing`

## Requirements
- R1: After reset, and while idle, pix_en_o, pix_req_o and done_o are 0, x_o and y_o are 0, and hsync_o, vsync_o, de_o, pclk_o and acb_o sit at their inactive level. That level is 0 after reset. Afterwards it is the polarity bit captured at the last frame start.
- R2: If enable_i is sampled high at a clock edge while idle, a frame starts at that edge, and the following cycle shows horizontal position 0 of line 0. hcfg_i, vcfg_i, ccfg_i and tft_i are captured only at a frame start. Changes between frame starts have no effect on the frame in progress.
- R3: The horizontal word is decoded as follows. Active pixels minus 1 are in bits 9:0, sync width minus 1 in bits 15:10, front porch minus 1 in bits 23:16 and back porch minus 1 in bits 31:24. Each line runs sync, back porch, active, front porch, in pixel periods. The hsync level is asserted during the sync part.
- R4: The pixel period is D cycles. D is ccfg bits 7:0, raised to 2 for TFT and to 3 for passive when smaller. pix_en_o pulses for one cycle at the last cycle of each period. The unasserted pclk level covers the first floor(D/2) cycles of a period, and the asserted level covers the rest.
- R5: The vertical word is decoded as follows. Active lines minus 1 are in bits 9:0 and sync width minus 1 in bits 15:10. Front porch lines are in bits 23:16 and back porch lines in bits 31:24, both stored without offset, so zero is allowed. Each frame runs sync, back porch, active, front porch, in lines. The vsync level is asserted during the sync part.
- R6: de_o is asserted only in the active pixels of active lines. Inside that window, x_o and y_o give the pixel and line index within the active area; outside it they are 0. pix_req_o equals de_o AND pix_en_o.
- R7: ccfg bits 20, 21, 22, 23 and 24 invert vsync_o, hsync_o, pclk_o, de_o and acb_o respectively when set. Bit 25 has no effect.
- R8: If enable_i is low at the edge that ends a frame's last pixel period, scanning stops at that edge and done_o is high for exactly the following cycle. If enable_i is high at that edge, the next frame starts with no gap.
- R9: In passive mode the AC-bias level starts at 0 at each start from idle. It toggles at the end of every N-th line, where N is ccfg bits 15:8 and 0 counts as 1.
- R10: tft_i high selects TFT operation. In that mode acb_o carries the data-enable level (before the acb polarity inversion) and the divider floor is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Logic clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run request; sampled while idle and at frame end |
| tft_i | input | 1 | 1 = TFT panel, 0 = passive panel |
| hcfg_i | input | 32 | Horizontal geometry word |
| vcfg_i | input | 32 | Vertical geometry word |
| ccfg_i | input | 32 | Divider, AC-bias count, polarity bits |
| pix_en_o | output | 1 | One-cycle pulse per pixel period |
| pclk_o | output | 1 | Pixel clock level |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| acb_o | output | 1 | AC-bias (passive) or data enable (TFT) |
| pix_req_o | output | 1 | Pixel request strobe inside the active window |
| x_o | output | 10 | Active pixel index |
| y_o | output | 10 | Active line index |
| done_o | output | 1 | One-cycle pulse after the final frame |

## Verification
The assertions assume that enable_i and the configuration words are synchronous to clk_i. They also rely on the divider floor keeping every pixel period at two cycles or more, which is why pixel-enable pulses never touch. The stimulus changes inputs only on the falling edge. It programs divider values below, at and above both floors, and it rewrites configuration in the middle of a frame so that shadow capture is exercised. The geometries are kept small so that several complete frames, including zero-length vertical porches, fit in the run.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;
  localparam int CW = 12;  // segment/total counter width
  localparam int PW = 10;  // coordinate width

  typedef struct packed {
    logic [CW-1:0] sync_len;
    logic [CW-1:0] bp_len;
    logic [CW-1:0] act_len;
    logic [CW-1:0] fp_len;
  } seg_t;

  // horizontal: every field stored minus one
  function automatic seg_t dec_h(input logic [31:0] r);
    seg_t s;
    s.sync_len = CW'(r[15:10]) + CW'(1);
    s.bp_len   = CW'(r[31:24]) + CW'(1);
    s.act_len  = CW'(r[9:0])   + CW'(1);
    s.fp_len   = CW'(r[23:16]) + CW'(1);
    return s;
  endfunction

  // vertical: porches stored as is
  function automatic seg_t dec_v(input logic [31:0] r);
    seg_t s;
    s.sync_len = CW'(r[15:10]) + CW'(1);
    s.bp_len   = CW'(r[31:24]);
    s.act_len  = CW'(r[9:0])   + CW'(1);
    s.fp_len   = CW'(r[23:16]);
    return s;
  endfunction
endpackage

// File: rtl/lcd_pix_div.sv
module lcd_pix_div #(
  parameter int DW      = 8,
  parameter int MIN_TFT = 2,
  parameter int MIN_PAS = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          clr_i,
  input  logic          tft_i,
  input  logic [DW-1:0] div_i,
  output logic          tick_o,
  output logic          pclk_o
);
  logic [DW-1:0] cnt_q, eff, floor_v;

  always_comb begin
    floor_v = tft_i ? DW'(MIN_TFT) : DW'(MIN_PAS);
    eff     = (div_i < floor_v) ? floor_v : div_i;
  end

  assign tick_o = run_i && (cnt_q == eff - DW'(1));
  assign pclk_o = run_i && (cnt_q >= (eff >> 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else if (run_i)   cnt_q <= cnt_q + DW'(1);
  end
endmodule

// File: rtl/lcd_scan_ctr.sv
module lcd_scan_ctr
  import lcd_timing_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  input  seg_t          seg_i,
  output logic          wrap_o,
  output logic          sync_o,
  output logic          act_o,
  output logic [PW-1:0] apos_o
);
  logic [CW-1:0] pos_q, total, act_beg, act_end, rel;

  always_comb begin
    act_beg = seg_i.sync_len + seg_i.bp_len;
    act_end = act_beg + seg_i.act_len;
    total   = act_end + seg_i.fp_len;
    rel     = pos_q - act_beg;
  end

  assign wrap_o = step_i && (pos_q == total - CW'(1));
  assign sync_o = pos_q < seg_i.sync_len;
  assign act_o  = (pos_q >= act_beg) && (pos_q < act_end);
  assign apos_o = act_o ? rel[PW-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pos_q <= '0;
    else if (clr_i)   pos_q <= '0;
    else if (wrap_o)  pos_q <= '0;
    else if (step_i)  pos_q <= pos_q + CW'(1);
  end
endmodule

// File: rtl/lcd_acb_gen.sv
module lcd_acb_gen #(
  parameter int NW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          line_end_i,
  input  logic [NW-1:0] lines_i,
  input  logic          tft_i,
  input  logic          de_i,
  output logic          acb_o
);
  logic [NW-1:0] lcnt_q, limit;
  logic          tog_q;

  assign limit = (lines_i == '0) ? NW'(1) : lines_i;
  assign acb_o = tft_i ? de_i : tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcnt_q <= '0;
      tog_q  <= 1'b0;
    end else if (!run_i) begin
      lcnt_q <= '0;
      tog_q  <= 1'b0;
    end else if (line_end_i) begin
      if (lcnt_q + NW'(1) >= limit) begin
        lcnt_q <= '0;
        tog_q  <= ~tog_q;
      end else begin
        lcnt_q <= lcnt_q + NW'(1);
      end
    end
  end
endmodule

// File: rtl/lcd_timing.sv
module lcd_timing
  import lcd_timing_pkg::*;
#(
  parameter int DIV_MIN_TFT = 2,
  parameter int DIV_MIN_PAS = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          tft_i,
  input  logic [31:0]   hcfg_i,
  input  logic [31:0]   vcfg_i,
  input  logic [31:0]   ccfg_i,
  output logic          pix_en_o,
  output logic          pclk_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          acb_o,
  output logic          pix_req_o,
  output logic [PW-1:0] x_o,
  output logic [PW-1:0] y_o,
  output logic          done_o
);
  localparam int POL_VS = 20;
  localparam int POL_HS = 21;
  localparam int POL_PC = 22;
  localparam int POL_DE = 23;
  localparam int POL_AC = 24;

  logic        run_q, done_q, tft_q;
  logic [31:0] hcfg_q, vcfg_q, ccfg_q;
  logic        start, load, stop, clr, frame_end;
  logic        tick, pclk_raw;
  logic        h_wrap, h_sync, h_act, v_sync, v_act;
  logic [PW-1:0] h_pos, v_pos;
  logic        de_raw, hs_raw, vs_raw, acb_raw;
  seg_t        hseg, vseg;

  assign start = !run_q && enable_i;
  assign load  = start || (frame_end && enable_i);
  assign stop  = frame_end && !enable_i;
  assign clr   = load || stop;
  assign hseg  = dec_h(hcfg_q);
  assign vseg  = dec_v(vcfg_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      tft_q  <= 1'b0;
      hcfg_q <= '0;
      vcfg_q <= '0;
      ccfg_q <= '0;
    end else begin
      done_q <= stop;
      if (load) begin
        run_q  <= 1'b1;
        tft_q  <= tft_i;
        hcfg_q <= hcfg_i;
        vcfg_q <= vcfg_i;
        ccfg_q <= ccfg_i;
      end else if (stop) begin
        run_q  <= 1'b0;
      end
    end
  end

  lcd_pix_div #(.DW(8), .MIN_TFT(DIV_MIN_TFT), .MIN_PAS(DIV_MIN_PAS)) u_div (
    .clk_i, .rst_ni, .run_i(run_q), .clr_i(clr), .tft_i(tft_q),
    .div_i(ccfg_q[7:0]), .tick_o(tick), .pclk_o(pclk_raw)
  );

  lcd_scan_ctr u_hscan (
    .clk_i, .rst_ni, .clr_i(clr), .step_i(tick), .seg_i(hseg),
    .wrap_o(h_wrap), .sync_o(h_sync), .act_o(h_act), .apos_o(h_pos)
  );

  lcd_scan_ctr u_vscan (
    .clk_i, .rst_ni, .clr_i(clr), .step_i(h_wrap), .seg_i(vseg),
    .wrap_o(frame_end), .sync_o(v_sync), .act_o(v_act), .apos_o(v_pos)
  );

  assign de_raw = run_q && h_act && v_act;
  assign hs_raw = run_q && h_sync;
  assign vs_raw = run_q && v_sync;

  lcd_acb_gen #(.NW(8)) u_acb (
    .clk_i, .rst_ni, .run_i(run_q), .line_end_i(h_wrap),
    .lines_i(ccfg_q[15:8]), .tft_i(tft_q), .de_i(de_raw), .acb_o(acb_raw)
  );

  assign pix_en_o  = tick;
  assign pix_req_o = de_raw && tick;
  assign x_o       = de_raw ? h_pos : '0;
  assign y_o       = de_raw ? v_pos : '0;
  assign done_o    = done_q;
  assign vsync_o   = vs_raw   ^ ccfg_q[POL_VS];
  assign hsync_o   = hs_raw   ^ ccfg_q[POL_HS];
  assign pclk_o    = pclk_raw ^ ccfg_q[POL_PC];
  assign de_o      = de_raw   ^ ccfg_q[POL_DE];
  assign acb_o     = acb_raw  ^ ccfg_q[POL_AC];
endmodule

// File: rtl/lcd_timing_chk.sv
module lcd_timing_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       run_q,
  input logic       tick,
  input logic       de_raw,
  input logic       hs_raw,
  input logic       done_o,
  input logic       pix_req_o,
  input logic [9:0] x_o,
  input logic [9:0] y_o
);
  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> !tick); // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !run_q); // R8
  AST_REQ_IN_DE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_req_o |-> de_raw); // R6
  AST_SYNC_NOT_DE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_raw |-> !de_raw); // R3
  AST_XY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !tick) |=> ($stable(x_o) && $stable(y_o))); // R6
endmodule

bind lcd_timing lcd_timing_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_q(run_q), .tick(tick),
  .de_raw(de_raw), .hs_raw(hs_raw), .done_o(done_o),
  .pix_req_o(pix_req_o), .x_o(x_o), .y_o(y_o)
);

// File: tb/lcd_timing_tb.sv
`timescale 1ns/1ps
module lcd_timing_tb;
  logic clk = 0, rst_n = 0, en = 0, tft = 0;
  logic [31:0] hcfg = 0, vcfg = 0, ccfg = 0;
  logic pix_en, pclk, hs, vs, de, acb, req, done;
  logic [9:0] x, y;
  int checks = 0, errors = 0;
  bit cmp_en = 0;

  always #2.5 clk = ~clk;

  lcd_timing u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .tft_i(tft),
    .hcfg_i(hcfg), .vcfg_i(vcfg), .ccfg_i(ccfg),
    .pix_en_o(pix_en), .pclk_o(pclk), .hsync_o(hs), .vsync_o(vs),
    .de_o(de), .acb_o(acb), .pix_req_o(req), .x_o(x), .y_o(y), .done_o(done)
  );

  // behavioural reference state
  int m_run, m_done, m_dc, m_h, m_v, m_ln, m_tog, s_tft;
  logic [31:0] s_h, s_v, s_c;

  function automatic int hs_n();  return s_h[15:10] + 1; endfunction
  function automatic int hb_n();  return s_h[31:24] + 1; endfunction
  function automatic int ha_n();  return s_h[9:0] + 1;   endfunction
  function automatic int hf_n();  return s_h[23:16] + 1; endfunction
  function automatic int vs_n();  return s_v[15:10] + 1; endfunction
  function automatic int vb_n();  return s_v[31:24];     endfunction
  function automatic int va_n();  return s_v[9:0] + 1;   endfunction
  function automatic int vf_n();  return s_v[23:16];     endfunction
  function automatic int div_n();
    int f = s_tft ? 2 : 3;
    return (s_c[7:0] < f) ? f : s_c[7:0];
  endfunction

  task automatic m_load();
    s_h = hcfg; s_v = vcfg; s_c = ccfg; s_tft = tft;
    m_run = 1; m_dc = 0; m_h = 0; m_v = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_done = 0; m_dc = 0; m_h = 0; m_v = 0; m_ln = 0; m_tog = 0;
      s_h = 0; s_v = 0; s_c = 0; s_tft = 0;
    end else begin
      int tk, hw, fe, n;
      m_done = 0;
      if (m_run == 0) begin
        m_ln = 0; m_tog = 0;
        if (en) m_load();
      end else begin
        tk = (m_dc == div_n() - 1);
        hw = tk && (m_h == hs_n() + hb_n() + ha_n() + hf_n() - 1);
        fe = hw && (m_v == vs_n() + vb_n() + va_n() + vf_n() - 1);
        if (hw) begin
          n = (s_c[15:8] == 0) ? 1 : s_c[15:8];
          if (m_ln + 1 >= n) begin m_ln = 0; m_tog ^= 1; end
          else m_ln++;
        end
        if (fe) begin
          if (en) m_load();
          else begin m_run = 0; m_done = 1; m_dc = 0; m_h = 0; m_v = 0; end
        end else begin
          m_dc = tk ? 0 : m_dc + 1;
          if (tk) m_h = hw ? 0 : m_h + 1;
          if (hw) m_v++;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      int tk, hact, vact, d, xe, ye;
      tk   = m_run && (m_dc == div_n() - 1);
      hact = (m_h >= hs_n() + hb_n()) && (m_h < hs_n() + hb_n() + ha_n());
      vact = (m_v >= vs_n() + vb_n()) && (m_v < vs_n() + vb_n() + va_n());
      d    = m_run && hact && vact;
      xe   = d ? m_h - hs_n() - hb_n() : 0;
      ye   = d ? m_v - vs_n() - vb_n() : 0;
      chk("R4 pix_en", pix_en, tk);
      chk("R4 pclk", pclk, (m_run && (m_dc >= div_n() / 2)) ^ s_c[22]);
      chk("R3 hsync", hs, (m_run && m_h < hs_n()) ^ s_c[21]);
      chk("R5 vsync", vs, (m_run && m_v < vs_n()) ^ s_c[20]);
      chk("R6 de", de, d ^ s_c[23]);
      chk("R6 x", x, xe);
      chk("R6 y", y, ye);
      chk("R6 pix_req", req, d && tk);
      chk("R9 acb", acb, (s_tft ? d : m_tog) ^ s_c[24]);
      chk("R8 done", done, m_done);
    end
  end

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (done) return;
    end
    chk("R8 done timeout", 0, 1);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int ndone;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 hsync", hs, 0); chk("R1 vsync", vs, 0); chk("R1 de", de, 0);
    chk("R1 done", done, 0); chk("R1 pix_en", pix_en, 0); chk("R1 x", x, 0);
    rst_n = 1;
    cmp_en = 1;
    repeat (5) @(negedge clk);
    chk("R1 idle pclk", pclk, 0);

    // TFT, divider 0 -> floor 2; h: act 8 sync 2 fp 1 bp 2; v: act 3 sync 1 fp 1 bp 1
    tft = 1;
    hcfg = {8'd1, 8'd0, 6'd1, 10'd7};
    vcfg = {8'd1, 8'd1, 6'd0, 10'd2};
    ccfg = 32'h0000_0000;
    en = 1;
    @(negedge clk);
    chk("R2 start hsync", hs, 1);
    chk("R2 start pix_en", pix_en, 0);
    // R2: mid-frame rewrite must not disturb this frame
    repeat (40) @(negedge clk);
    hcfg = {8'd0, 8'd2, 6'd0, 10'd5};
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (de) begin chk("R10 acb follows de", acb, de); break; end
    end
    repeat (300) @(negedge clk);
    en = 0;
    wait_done(2000);
    ndone = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); ndone += done; end
    chk("R8 single done", ndone, 0);

    // passive, divider 1 -> floor 3, acb every 2 lines, all polarities inverted
    tft = 0;
    hcfg = {8'd0, 8'd1, 6'd0, 10'd3};
    vcfg = {8'd0, 8'd0, 6'd1, 10'd3};
    ccfg = (32'h3F << 20) | (32'd2 << 8) | 32'd1;
    en = 1;
    repeat (900) @(negedge clk);
    en = 0;
    wait_done(2000);
    repeat (2) @(negedge clk);
    // R7: idle levels follow the inverted polarity
    chk("R7 idle hsync", hs, 1); chk("R7 idle vsync", vs, 1);
    chk("R7 idle de", de, 1); chk("R7 idle pclk", pclk, 1); chk("R7 idle acb", acb, 1);

    // passive, divider 5, acb count 0 -> every line, vertical porches zero
    ccfg = 32'd5;
    vcfg = {8'd0, 8'd0, 6'd0, 10'd1};
    en = 1;
    repeat (700) @(negedge clk);
    en = 0;
    wait_done(2000);

    // TFT, divider 4, back-to-back frames then stop
    tft = 1;
    ccfg = (32'd1 << 23) | 32'd4;
    hcfg = {8'd2, 8'd1, 6'd2, 10'd9};
    vcfg = {8'd2, 8'd1, 6'd1, 10'd2};
    en = 1;
    repeat (2500) @(negedge clk);
    en = 0;
    wait_done(4000);
    repeat (10) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule